// File: doc/BRIEF.md
# Multi-mode 16-bit timer/counter

This block is a 16-bit timer/counter built from a low byte and a high byte. A two-stage prescaler divides a cycle-rate clock enable. The first stage is a fixed divide-by-four. The second stage is an 8-bit divider whose reload value comes from an input. The byte pair can be run in four arrangements, chosen by a 2-bit mode input:
- two independent prescaled 8-bit timers;
- a prescaled 8-bit timer plus an 8-bit counter of external events;
- one cascaded 16-bit prescaled timer;
- one cascaded 16-bit event counter.

Each byte compares its count with its own match input. On the count tick where the count equals the match value, the counter returns to zero and sets its own sticky request flag. Software clears a flag with a one-cycle write-1 pulse. In the cascaded modes the full 16-bit value is compared with the two match inputs joined, and only the high-byte flag is used.

The external event pin is synchronised inside the block, and only rising edges are counted. The prescaler output pulse is exported so that other timers can use it. A change of the mode or of the reload value restarts the counters and the prescaler.

Top module: `tmr16_multi`

## Requirements
- R1: After reset, both counts, both flags and the prescaler output are 0.
- R2: `pre_tick` pulses for one cycle once every 4*(reload+1) cycles in which `cyc_en` is high. The prescaler and the prescaled counters hold their value while `cyc_en` is low.
- R3: In mode 0 (`mode`=2'b00) each byte counts prescaler pulses on its own. On a pulse where a byte equals its match value, that byte goes to 0 and sets its flag; otherwise it increments.
- R4: In mode 1 (`mode`=2'b01) the low byte behaves as in R3. The high byte counts rising edges of `evt_in` against `hi_match`, with the same wrap and flag rule.
- R5: In mode 2 (`mode`=2'b10) {high,low} form one 16-bit counter of prescaler pulses. It is compared with {`hi_match`,`lo_match`}, and a carry passes from the low byte into the high byte. A match sets `hi_flag` only; `lo_flag` never rises in this mode.
- R6: In mode 3 (`mode`=2'b11) {high,low} form one 16-bit counter of `evt_in` rising edges. It follows the same match and flag rule as R5.
- R7: An event pulse that is high for one clock and low for one clock is counted once. The count shows each edge within three clock edges of the pin changing. Event counting does not depend on `cyc_en`.
- R8: Flags are sticky. A one-cycle pulse on `lo_clr` or `hi_clr` clears only its own flag. A set in the same cycle wins over the clear.
- R9: A change of `mode` or `pre_reload` clears both counters and both prescaler stages on the next clock edge, and leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_en | input | 1 | Cycle-rate count enable |
| evt_in | input | 1 | External event pin (asynchronous) |
| mode | input | 2 | Mode select (0..3) |
| pre_reload | input | 8 | Programmable prescaler reload value |
| lo_match | input | 8 | Low-byte match value |
| hi_match | input | 8 | High-byte match value |
| lo_clr | input | 1 | Write-1 clear of low flag |
| hi_clr | input | 1 | Write-1 clear of high flag |
| pre_tick | output | 1 | Prescaler output pulse |
| lo_count | output | 8 | Low-byte count |
| hi_count | output | 8 | High-byte count |
| lo_flag | output | 1 | Low-byte request flag |
| hi_flag | output | 1 | High-byte request flag |

## Verification
The bench targets these corner cases:
- **Carry across the byte boundary in mode 2.** A design that compared the bytes separately would wrap early.
- **A full-range 16-bit match.** A design that let `lo_flag` rise in a cascaded mode would raise a spurious request.
- **The exact prescaler period.** An off-by-one in either stage would move `pre_tick` by whole cycles.
- **One-cycle event pulses.** A level-sensitive or cyc_en-gated event path would miscount them.
- **Configuration change.** Ignoring it would leave stale counts.
- **Selective flag clear.** Clearing both flags would show in the untouched flag.

// File: rtl/tmr16_multi.sv
module tmr16_multi #(
  parameter int BYTE_W = 8,
  parameter int FIX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_en,
  input  logic              evt_in,
  input  logic [1:0]        mode,
  input  logic [BYTE_W-1:0] pre_reload,
  input  logic [BYTE_W-1:0] lo_match,
  input  logic [BYTE_W-1:0] hi_match,
  input  logic              lo_clr,
  input  logic              hi_clr,
  output logic              pre_tick,
  output logic [BYTE_W-1:0] lo_count,
  output logic [BYTE_W-1:0] hi_count,
  output logic              lo_flag,
  output logic              hi_flag
);
  localparam int FULL_W = 2 * BYTE_W;

  logic [1:0]        mode_q;
  logic [BYTE_W-1:0] reload_q;
  logic [FIX_W-1:0]  fix_cnt;
  logic [BYTE_W-1:0] div_cnt;
  logic [2:0]        evt_sh;
  logic [BYTE_W-1:0] lo_cnt, hi_cnt;

  wire cfg_chg  = (mode != mode_q) || (pre_reload != reload_q);
  wire fix_tick = cyc_en && (fix_cnt == {FIX_W{1'b1}});
  assign pre_tick = fix_tick && (div_cnt == reload_q) && !cfg_chg;

  wire evt_tick = evt_sh[1] && !evt_sh[2];
  wire cascade  = mode_q[1];
  wire tick_lo  = (mode_q == 2'b11) ? evt_tick : pre_tick;
  wire tick_hi  = (mode_q == 2'b01) ? evt_tick : pre_tick;

  wire [FULL_W-1:0] full_cnt = {hi_cnt, lo_cnt};
  wire [FULL_W-1:0] full_mat = {hi_match, lo_match};
  wire [FULL_W-1:0] full_inc = full_cnt + 1'b1;

  wire lo_hit = !cfg_chg && !cascade && tick_lo && (lo_cnt == lo_match);
  wire hi_hit = !cfg_chg && (cascade ? (tick_lo && full_cnt == full_mat)
                                     : (tick_hi && hi_cnt == hi_match));

  always_ff @(posedge clk) begin
    if (!rst_n) evt_sh <= '0;
    else        evt_sh <= {evt_sh[1:0], evt_in};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0; reload_q <= '0; fix_cnt <= '0; div_cnt <= '0;
      lo_cnt <= '0; hi_cnt <= '0;
    end else if (cfg_chg) begin
      mode_q <= mode; reload_q <= pre_reload; fix_cnt <= '0; div_cnt <= '0;
      lo_cnt <= '0; hi_cnt <= '0;
    end else begin
      if (cyc_en) fix_cnt <= fix_cnt + 1'b1;
      if (fix_tick) div_cnt <= (div_cnt == reload_q) ? '0 : div_cnt + 1'b1;
      if (cascade) begin
        if (tick_lo) {hi_cnt, lo_cnt} <= (full_cnt == full_mat) ? '0 : full_inc;
      end else begin
        if (tick_lo) lo_cnt <= (lo_cnt == lo_match) ? '0 : lo_cnt + 1'b1;
        if (tick_hi) hi_cnt <= (hi_cnt == hi_match) ? '0 : hi_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_flag <= 1'b0; hi_flag <= 1'b0;
    end else begin
      lo_flag <= (lo_flag && !lo_clr) || lo_hit;
      hi_flag <= (hi_flag && !hi_clr) || hi_hit;
    end
  end

  assign lo_count = lo_cnt;
  assign hi_count = hi_cnt;

  AST_CFG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> (lo_count == '0 && hi_count == '0)); // R9
  AST_LO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_chg && !cascade && tick_lo && lo_count == lo_match) |=> (lo_count == '0 && lo_flag)); // R3
  AST_CASCADE_NO_LOFLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cascade && !cfg_chg) |=> !$rose(lo_flag)); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_flag && !lo_clr) |=> lo_flag); // R8
  AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_en && !cfg_chg && mode_q != 2'b11) |=> $stable(lo_count)); // R2
endmodule

// File: tb/tmr16_multi_tb_top.sv
module tmr16_multi_tb_top;
  logic clk = 0, rst_n = 0, cyc_en = 0, evt_in = 0, lo_clr = 0, hi_clr = 0;
  logic [1:0] mode = 0;
  logic [7:0] pre_reload = 0, lo_match = 0, hi_match = 0;
  logic pre_tick, lo_flag, hi_flag;
  logic [7:0] lo_count, hi_count;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tmr16_multi dut_i (.clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .evt_in(evt_in),
    .mode(mode), .pre_reload(pre_reload), .lo_match(lo_match), .hi_match(hi_match),
    .lo_clr(lo_clr), .hi_clr(hi_clr), .pre_tick(pre_tick), .lo_count(lo_count),
    .hi_count(hi_count), .lo_flag(lo_flag), .hi_flag(hi_flag));

  localparam int NV = 7;
  localparam int V_MODE [NV] = '{0, 0, 1, 2, 2, 3, 1};
  localparam int V_PRE  [NV] = '{0, 2, 1, 0, 0, 0, 0};
  localparam int V_LM   [NV] = '{4, 200, 2, 3, 44, 5, 255};
  localparam int V_HM   [NV] = '{9, 3, 5, 0, 1, 0, 255};
  localparam int V_N    [NV] = '{100, 120, 200, 400, 1200, 100, 40};
  localparam int V_E    [NV] = '{0, 0, 7, 0, 0, 20, 3};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic setup(input int m, input int p, input int lm, input int hm);
    @(negedge clk);
    rst_n = 0; cyc_en = 0; evt_in = 0;
    mode = 2'(m); pre_reload = 8'(p); lo_match = 8'(lm); hi_match = 8'(hm);
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    lo_clr = 1; hi_clr = 1;
    @(negedge clk);
    lo_clr = 0; hi_clr = 0;
  endtask

  task automatic run(input int n, input int e);
    cyc_en = 1;
    for (int i = 0; i < n; i++) begin
      evt_in = ((i % 4) < 2) && ((i / 4) < e);
      @(negedge clk);
    end
    cyc_en = 0; evt_in = 0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int first, second, lo_keep;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 lo_count", lo_count, 0); chk("R1 hi_count", hi_count, 0);
    chk("R1 lo_flag", lo_flag, 0);   chk("R1 hi_flag", hi_flag, 0);
    chk("R1 pre_tick", pre_tick, 0);

    // Vector table: R3 R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      int per, t, src, mfull, c, elo, ehi, elf, ehf;
      setup(V_MODE[v], V_PRE[v], V_LM[v], V_HM[v]);
      run(V_N[v], V_E[v]);
      per = 4 * (V_PRE[v] + 1);
      t = V_N[v] / per;
      if (V_MODE[v] < 2) begin
        elo = t % (V_LM[v] + 1); elf = (t > V_LM[v]) ? 1 : 0;
        src = (V_MODE[v] == 1) ? V_E[v] : t;
        ehi = src % (V_HM[v] + 1); ehf = (src > V_HM[v]) ? 1 : 0;
      end else begin
        src = (V_MODE[v] == 3) ? V_E[v] : t;
        mfull = V_HM[v] * 256 + V_LM[v];
        c = src % (mfull + 1);
        elo = c % 256; ehi = c / 256; elf = 0; ehf = (src > mfull) ? 1 : 0;
      end
      chk($sformatf("R3-6 vec%0d lo_count", v), lo_count, elo);
      chk($sformatf("R3-6 vec%0d hi_count", v), hi_count, ehi);
      chk($sformatf("R3-6 vec%0d lo_flag", v), lo_flag, elf);
      chk($sformatf("R3-6 vec%0d hi_flag", v), hi_flag, ehf);
    end

    // R8: after vector 0 style run both flags set; clear low only
    setup(0, 0, 4, 9);
    run(100, 0);
    @(negedge clk); lo_clr = 1; @(negedge clk); lo_clr = 0; @(negedge clk);
    chk("R8 lo_flag cleared", lo_flag, 0);
    chk("R8 hi_flag kept", hi_flag, 1);

    // R2: prescaler period, reload 3 -> pulse every 16 enabled cycles
    setup(0, 3, 255, 255);
    cyc_en = 1; first = -1; second = -1;
    for (int k = 0; k < 40; k++) begin
      if (pre_tick) begin
        if (first < 0) first = k; else if (second < 0) second = k;
      end
      @(negedge clk);
    end
    cyc_en = 0;
    chk("R2 first pre_tick", first, 15);
    chk("R2 pre_tick spacing", second - first, 16);
    // R2: hold while cyc_en low
    lo_keep = lo_count;
    repeat (20) @(negedge clk);
    chk("R2 hold lo_count", lo_count, lo_keep);
    chk("R2 no pre_tick when disabled", pre_tick, 0);

    // R9: config change clears counters, keeps flags
    setup(0, 0, 1, 255);
    run(12, 0);
    chk("R9 pre lo_count", lo_count, 1);
    chk("R9 pre lo_flag", lo_flag, 1);
    pre_reload = 8'd1;
    @(negedge clk);
    chk("R9 lo_count cleared", lo_count, 0);
    chk("R9 hi_count cleared", hi_count, 0);
    chk("R9 lo_flag kept", lo_flag, 1);

    // R7: one-cycle high / one-cycle low event pulses, cyc_en low
    setup(3, 0, 255, 255);
    for (int k = 0; k < 5; k++) begin
      evt_in = 1; @(negedge clk);
      evt_in = 0; @(negedge clk);
    end
    @(negedge clk);
    chk("R7 narrow pulses counted", lo_count, 5);
    evt_in = 1; @(negedge clk); @(negedge clk); @(negedge clk);
    chk("R7 edge latency", lo_count, 6);
    evt_in = 0; @(negedge clk);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule